// File: doc/BRIEF.md
# Sequential Fixed-Point Rounding Divider

This block divides one signed fixed-point number by another. Both operands and the result use the same two's-complement Q-format: `W` bits in total, `FRAC` of them fractional. Division costs too much logic to finish in one cycle, so the block resolves one quotient bit per clock.

The block first takes the magnitudes of both operands. It shifts the dividend magnitude left by `FRAC` into a register twice the word width and adds half the divisor magnitude as a rounding bias. It then runs `2*W` restoring shift-subtract steps. The sign is applied to the quotient magnitude at the end, so quotients of either sign round to nearest, with halves rounded away from zero. The low `W` bits of the signed quotient become the result.

A zero divisor skips the iteration. It raises a flag and returns the extreme code whose sign matches the dividend.

The controller is a three-state machine:
- `ST_IDLE` waits for `start`. On `start` it goes to `ST_RUN` when the divisor is non-zero, and to `ST_FINISH` when the divisor is zero.
- `ST_RUN` performs one division step per cycle. It moves to `ST_FINISH` after the last step.
- `ST_FINISH` presents `done` for one cycle and always returns to `ST_IDLE`.

Top module: `fxq_round_div`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero` and `quotient` are all 0.
- R2: For a non-zero divisor Y and dividend X, the magnitude of the result is q = floor((|X|·2^FRAC + floor(|Y|/2)) / |Y|). The result is −q when exactly one operand is negative, and +q otherwise.
- R3: Rounding is sign-symmetric: for every X and non-zero Y with X not the most negative code, result(−X, Y) equals the W-bit two's-complement negation of result(X, Y).
- R4: A quotient that does not fit in W bits is not saturated: the output holds the low W bits of the signed quotient.
- R5: With a non-zero divisor, `done` is high in the cycle after the 2·W-th rising edge that follows the edge accepting `start`. `busy` is high from the cycle after acceptance until `done` has been shown.
- R6: `done` is high for exactly one cycle per accepted operation.
- R7: `start` is ignored while `busy` is high. The operation in progress keeps its operands and its latency, and the block returns to idle after `done`.
- R8: A zero divisor sets `div_zero`, with `done` in the cycle after the accepting edge. The result is 0 followed by W−1 ones when the dividend is zero or positive, and 1 followed by W−1 zeros when the dividend is negative.
- R9: `div_zero` is 0 with every result from a non-zero divisor.
- R10: `quotient` and `div_zero` keep their values between `done` pulses, whatever happens on `dividend` and `divisor`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division; accepted only when idle |
| dividend | input | W | Signed numerator in the Q-format |
| divisor | input | W | Signed denominator in the Q-format |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Single-cycle completion strobe |
| quotient | output | W | Rounded signed result in the Q-format |
| div_zero | output | 1 | Last result came from a zero divisor |

## Verification
A wrong remainder or a misplaced quotient bit inside the step loop only shows once the operation completes. It appears 2·W cycles later as a wrong `quotient` value when `done` is high. The sweep over every operand pair of a small configuration exposes such an error, and also any rounding or sign error for each sign combination. A state machine that leaves `ST_RUN` early or late, or that accepts a second `start`, appears at once as a changed cycle count to `done` or as a result taken from the wrong operands.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } fxdiv_state_e;
endpackage

// File: rtl/fxdiv_prep.sv
// Operand conditioning: magnitudes, signs, scaled and biased numerator.
module fxdiv_prep #(
    parameter int W    = 8,
    parameter int FRAC = 3
) (
    input  logic [W-1:0]   dividend,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] num,
    output logic [W-1:0]   dmag,
    output logic           neg,
    output logic           dvd_neg,
    output logic           zero
);
    localparam int DW = 2 * W;

    logic [W-1:0] xmag;

    always_comb begin
        dvd_neg = dividend[W-1];
        xmag    = dividend[W-1] ? (~dividend + 1'b1) : dividend;
        dmag    = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
        neg     = dividend[W-1] ^ divisor[W-1];
        zero    = (divisor == '0);
        num     = ({{W{1'b0}}, xmag} << FRAC) + DW'(dmag >> 1);
    end
endmodule

// File: rtl/fxdiv_step.sv
// One restoring shift-subtract step.
module fxdiv_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] rem,
    input  logic         in_bit,
    input  logic [W-1:0] dmag,
    output logic [W-1:0] rem_nx,
    output logic         q_bit
);
    logic [W:0] trial;
    logic [W:0] diff;

    always_comb begin
        trial  = {rem, in_bit};
        diff   = trial - {1'b0, dmag};
        q_bit  = (trial >= {1'b0, dmag});
        rem_nx = q_bit ? diff[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/fxdiv_pack.sv
// Sign restoration, word truncation and zero-divisor extreme code.
module fxdiv_pack #(
    parameter int W = 8
) (
    input  logic [W-1:0] qmag,
    input  logic         neg,
    input  logic         dz,
    input  logic         dvd_neg,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] POS_EXT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_EXT = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (dz)
            res = dvd_neg ? NEG_EXT : POS_EXT;
        else
            res = neg ? (~qmag + 1'b1) : qmag;
    end
endmodule

// File: rtl/fxq_round_div.sv
module fxq_round_div #(
    parameter int W    = 8,
    parameter int FRAC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic         div_zero
);
    import fxdiv_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    fxdiv_state_e state_q, state_d;

    logic [DW-1:0] num_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  dmag_q;
    logic          neg_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  quot_q;
    logic          dz_q;

    logic [DW-1:0] p_num;
    logic [W-1:0]  p_dmag;
    logic          p_neg, p_dvd_neg, p_zero;
    logic [W-1:0]  s_rem;
    logic          s_qbit;
    logic [W-1:0]  k_res;
    logic          accept;

    fxdiv_prep #(.W(W), .FRAC(FRAC)) u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .num      (p_num),
        .dmag     (p_dmag),
        .neg      (p_neg),
        .dvd_neg  (p_dvd_neg),
        .zero     (p_zero)
    );

    fxdiv_step #(.W(W)) u_step (
        .rem    (rem_q),
        .in_bit (num_q[DW-1]),
        .dmag   (dmag_q),
        .rem_nx (s_rem),
        .q_bit  (s_qbit)
    );

    fxdiv_pack #(.W(W)) u_pack (
        .qmag    ({num_q[W-2:0], s_qbit}),
        .neg     (neg_q),
        .dz      (state_q == ST_IDLE),
        .dvd_neg (p_dvd_neg),
        .res     (k_res)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = p_zero ? ST_FINISH : ST_RUN;
            ST_RUN:    if (cnt_q == LAST) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FINISH);
        quotient = quot_q;
        div_zero = dz_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q  <= '0;
            rem_q  <= '0;
            dmag_q <= '0;
            neg_q  <= 1'b0;
            cnt_q  <= '0;
            quot_q <= '0;
            dz_q   <= 1'b0;
        end else begin
            if (accept) begin
                num_q  <= p_num;
                rem_q  <= '0;
                dmag_q <= p_dmag;
                neg_q  <= p_neg;
                cnt_q  <= '0;
            end else if (state_q == ST_RUN) begin
                num_q <= {num_q[DW-2:0], s_qbit};
                rem_q <= s_rem;
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_d == ST_FINISH && state_q != ST_FINISH) begin
                quot_q <= k_res;
                dz_q   <= (state_q == ST_IDLE);
            end
        end
    end
endmodule

// File: rtl/fxq_round_div_chk.sv
module fxq_round_div_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic         div_zero
);
    localparam logic [W-1:0] POS_EXT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_EXT = {1'b1, {(W-1){1'b0}}};

    // R5
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    // R8
    zero_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == POS_EXT || quotient == NEG_EXT));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(div_zero)));
endmodule

bind fxq_round_div fxq_round_div_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .quotient (quotient),
    .div_zero (div_zero)
);

// File: tb/fxq_round_div_tb.sv
module fxq_round_div_tb;
    localparam int W    = 6;
    localparam int FRAC = 2;
    localparam int DW   = 2 * W;
    localparam int MASK = (1 << W) - 1;
    localparam int HALF = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] quotient;

    int n_chk = 0;
    int n_bad = 0;
    int table_q [0:(1<<W)-1][0:(1<<W)-1];

    always #5 clk = ~clk;

    fxq_round_div #(.W(W), .FRAC(FRAC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .div_zero(div_zero)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_div(input int x, input int y);
        int ax, ay, q;
        if (y == 0) return (x < 0) ? HALF : (HALF - 1);
        ax = (x < 0) ? -x : x;
        ay = (y < 0) ? -y : y;
        q  = ((ax << FRAC) + (ay >> 1)) / ay;
        if ((x < 0) != (y < 0)) q = -q;
        return q & MASK;
    endfunction

    // runs one op; hold_start keeps start high through the whole operation
    task automatic run_op(input int x, input int y, input bit hold_start,
                          output int res, output int dz, output int lat);
        @(negedge clk);
        dividend = W'(x);
        divisor  = W'(y);
        start    = 1'b1;
        @(negedge clk);
        if (!hold_start) start = 1'b0;
        else begin
            dividend = W'(x + 7);
            divisor  = W'(y + 3);
        end
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        res = int'(quotient);
        dz  = int'(div_zero);
        @(negedge clk);
        check("R6", int'(done), 0, "done second cycle");
        if (hold_start) begin
            check("R7", int'(busy), 0, "busy after done with start held");
            start = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int res, dz, lat, exp;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", int'(busy), 0, "busy");
        check("R1", int'(done), 0, "done");
        check("R1", int'(div_zero), 0, "div_zero");
        check("R1", int'(quotient), 0, "quotient");
        rst_n = 1'b1;

        // exhaustive sweep: R2, R4, R5, R8, R9
        for (int x = -HALF; x < HALF; x++) begin
            for (int y = -HALF; y < HALF; y++) begin
                run_op(x, y, 1'b0, res, dz, lat);
                table_q[x & MASK][y & MASK] = res;
                exp = ref_div(x, y);
                if (y == 0) begin
                    check("R8", res, exp, $sformatf("zero-div result x=%0d", x));
                    check("R8", dz, 1, "div_zero flag");
                    check("R8", lat, 0, "zero-div latency");
                end else begin
                    check("R2_R4", res, exp, $sformatf("quotient x=%0d y=%0d", x, y));
                    check("R9", dz, 0, "div_zero clear");
                    check("R5", lat, DW, "latency");
                end
            end
        end

        // R3 sign symmetry
        for (int x = -HALF + 1; x < HALF; x++) begin
            for (int y = -HALF; y < HALF; y++) begin
                if (y != 0)
                    check("R3", table_q[(-x) & MASK][y & MASK],
                          (-table_q[x & MASK][y & MASK]) & MASK,
                          $sformatf("symmetry x=%0d y=%0d", x, y));
            end
        end

        // R7 start held high with changing operands during the run
        run_op(13, -5, 1'b1, res, dz, lat);
        check("R7", res, ref_div(13, -5), "result of first operands");
        check("R7", lat, DW, "latency unchanged");
        run_op(-9, 0, 1'b1, res, dz, lat);
        check("R7", res, ref_div(-9, 0), "zero-div with start held");

        // R10 outputs hold while idle
        run_op(21, 2, 1'b0, res, dz, lat);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            dividend = W'(k * 11);
            divisor  = W'(k);
            check("R10", int'(quotient), res, "quotient held");
            check("R10", int'(div_zero), 0, "flag held");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule